// File: doc/BRIEF.md
# Bus-Side Single-Word Read Responder

This block answers a single-word read issued by a host on a shared 68-bit data bus in a cascadable search device. The host presents a read request together with an address word. The block compares the address word's device-identity field with its own strapped identity. It decodes which storage space is addressed and forms the word location. It then runs a fixed six-cycle handshake on the data bus and on an acknowledge line. The data bus and the acknowledge line are modelled as value/enable pairs rather than true tri-states, so every cycle's drive state can be observed. A driven-off output always reads 0.

Locations in the data array, the mask array and the external SRAM can be given directly, or indirectly through one of eight 15-bit segment-select registers. An indirect location takes its upper thirteen bits from the selected register. Each of its two lowest bits is the OR of the register bit and the matching address-word bit. Internal registers are always addressed directly. The storage behind all four spaces is a simple internal memory with a load port. Each space holds 2^MEM_AW words, and the register space holds at least 64 words.

The sequencer has six states. ST_IDLE waits for a request. ST_ADDR reads the memory. ST_TURN keeps the bus released. ST_LEAD drives the bus high and holds acknowledge low. ST_DATA presents the word with acknowledge high. ST_TAIL releases the bus and holds acknowledge low. ST_IDLE moves to ST_ADDR on a request with a matching identity, and otherwise stays in ST_IDLE. Every other state advances unconditionally to the next, and ST_TAIL returns to ST_IDLE.

Top module: `rd_responder`

## Requirements
- R1: After reset the block is in ST_IDLE and dq_oe, dq_out, ack_oe and ack_out are all 0. All eight segment-select registers read 0.
- R2: A request whose address-word bits [25:21] differ from my_id is ignored. No output is driven in the following cycles.
- R3: Address-word bits [20:19] select the space: 0 data array, 1 mask array, 2 external SRAM, 3 internal register. Each space returns its own stored word.
- R4: With bit [29] = 0, an array or SRAM location is bits [14:0] of the address word. The low MEM_AW bits of that location select the stored word.
- R5: With bit [29] = 1, bits [28:26] pick segment register S, and the location is {S[14:2], S[1] | dq[1], S[0] | dq[0]}. Address-word bits [14:2] have no effect.
- R6: A register-space read uses address-word bits [5:0] as the register index, whatever bits [29:26] hold.
- R7: In the two cycles after the request (cycles 2 and 3), neither dq_oe nor ack_oe is asserted.
- R8: In cycle 4, dq_oe = 1 with dq_out all ones, and ack_oe = 1 with ack_out = 0.
- R9: In cycle 5, dq_out carries the addressed word with dq_oe = 1, and ack_out = 1 with ack_oe = 1.
- R10: In cycle 6, dq_oe = 0 and ack_oe = 1 with ack_out = 0. In cycle 7, ack_oe = 0.
- R11: A request raised while a read is in progress is ignored. A request in cycle 7 starts a new read at once.
- R12: A cycle with ssr_we = 1 writes ssr_wdata into segment register ssr_sel, and that value is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | 5 | Strapped device identity |
| rd_req | input | 1 | Read request, valid for one cycle with the address word |
| dq_in | input | 68 | Address word from the host |
| dq_out | output | 68 | Data-bus drive value |
| dq_oe | output | 1 | Data-bus drive enable |
| ack_out | output | 1 | Acknowledge drive value |
| ack_oe | output | 1 | Acknowledge drive enable |
| ssr_we | input | 1 | Segment-select register write strobe |
| ssr_sel | input | 3 | Segment-select register number |
| ssr_wdata | input | 15 | Segment-select register write value |
| ld_we | input | 1 | Storage load strobe |
| ld_space | input | 2 | Storage space to load |
| ld_index | input | IDX_W | Word index within the space |
| ld_data | input | 68 | Word to load |

## Verification
The bench builds the block with its default MEM_AW of 6, so every space holds 64 words. This lets the bench load a distinct, computable word into every location of all four spaces. A direct location above 63 then aliases onto its low six bits, which makes the R4 truncation visible. Because each space is only 64 words deep, the OR of the two low bits in indirect mode lands on a word that the bench can predict and that differs from its neighbours.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

    localparam int DQ_W     = 68;
    localparam int ID_W     = 5;
    localparam int LOC_W    = 15;
    localparam int SSR_N    = 8;
    localparam int SSR_SW   = $clog2(SSR_N);
    localparam int RADR_W   = 6;

    localparam int SPACE_LO = 19;
    localparam int SPACE_HI = 20;
    localparam int ID_LO    = 21;
    localparam int ID_HI    = 25;
    localparam int SEG_LO   = 26;
    localparam int SEG_HI   = 28;
    localparam int IND_BIT  = 29;

    typedef enum logic [1:0] {
        SP_DATA = 2'd0,
        SP_MASK = 2'd1,
        SP_SRAM = 2'd2,
        SP_REG  = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_TURN = 3'd2,
        ST_LEAD = 3'd3,
        ST_DATA = 3'd4,
        ST_TAIL = 3'd5
    } state_e;

endpackage

// File: rtl/rdr_ssr_bank.sv
module rdr_ssr_bank
    import rdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SSR_SW-1:0] wsel,
    input  logic [LOC_W-1:0]  wdata,
    input  logic [SSR_SW-1:0] rsel,
    output logic [LOC_W-1:0]  rdata
);

    logic [LOC_W-1:0] seg_q [SSR_N];

    for (genvar g = 0; g < SSR_N; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (we && (wsel == SSR_SW'(g))) begin
                seg_q[g] <= wdata;
            end
        end
    end

    assign rdata = seg_q[rsel];

    // R12: a write lands in the selected register
    assert_seg_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> seg_q[$past(wsel)] == $past(wdata));

endmodule

// File: rtl/rdr_addr_decode.sv
module rdr_addr_decode
    import rdr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [DQ_W-1:0]   word,
    input  logic [ID_W-1:0]   my_id,
    input  logic [LOC_W-1:0]  seg_val,
    output logic [SSR_SW-1:0] seg_sel,
    output logic              id_hit,
    output logic [IDX_W+1:0]  mem_idx
);

    space_e           space;
    logic             indirect;
    logic [LOC_W-1:0] loc;
    logic [IDX_W-1:0] idx;

    always_comb begin
        space    = space_e'(word[SPACE_HI:SPACE_LO]);
        indirect = word[IND_BIT];
        seg_sel  = word[SEG_HI:SEG_LO];
        id_hit   = (word[ID_HI:ID_LO] == my_id);

        if (indirect) begin
            loc = {seg_val[LOC_W-1:2], seg_val[1] | word[1], seg_val[0] | word[0]};
        end else begin
            loc = word[LOC_W-1:0];
        end

        unique case (space)
            SP_REG:  idx = IDX_W'(word[RADR_W-1:0]);
            default: idx = loc[IDX_W-1:0];
        endcase

        mem_idx = {space, idx};
    end

endmodule

// File: rtl/rdr_store.sv
module rdr_store
    import rdr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W+1:0] waddr,
    input  logic [DQ_W-1:0]  wdata,
    input  logic             re,
    input  logic [IDX_W+1:0] raddr,
    output logic [DQ_W-1:0]  rdata
);

    localparam int DEPTH = 4 << IDX_W;

    logic [DQ_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/rdr_seq.sv
module rdr_seq
    import rdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic id_hit,
    output logic accept,
    output logic mem_re,
    output logic drive_lead,
    output logic drive_data,
    output logic ack_oe,
    output logic ack_out
);

    state_e state_q;
    state_e state_d;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req && id_hit) begin
                    accept  = 1'b1;
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: state_d = ST_TURN;
            ST_TURN: state_d = ST_LEAD;
            ST_LEAD: state_d = ST_DATA;
            ST_DATA: state_d = ST_TAIL;
            ST_TAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        mem_re     = 1'b0;
        drive_lead = 1'b0;
        drive_data = 1'b0;
        ack_oe     = 1'b0;
        ack_out    = 1'b0;
        unique case (state_q)
            ST_ADDR: mem_re = 1'b1;
            ST_LEAD: begin
                drive_lead = 1'b1;
                ack_oe     = 1'b1;
            end
            ST_DATA: begin
                drive_data = 1'b1;
                ack_oe     = 1'b1;
                ack_out    = 1'b1;
            end
            ST_TAIL: ack_oe = 1'b1;
            default: ;
        endcase
    end

    // R2: a request with a foreign identity keeps the sequencer idle
    assert_foreign_id_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rd_req && !id_hit) |=> state_q == ST_IDLE);

    // R7: turnaround cycle keeps everything released
    assert_turn_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TURN) |-> !(drive_lead || drive_data || ack_oe));

    // R8: the lead cycle is followed by the data cycle with acknowledge high
    assert_lead_then_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_lead |=> drive_data && ack_out);

    // R9: acknowledge high only while data is on the bus
    assert_ack_high_with_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe && ack_out) |-> drive_data);

    // R10: after the data cycle the bus is released and acknowledge held low
    assert_tail_after_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_data |=> ack_oe && !ack_out && !drive_data && !drive_lead);

    // R11: a busy sequencer does not restart on a request
    assert_busy_ignores_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && rd_req) |=> state_q != ST_ADDR);

endmodule

// File: rtl/rd_responder.sv
module rd_responder
    import rdr_pkg::*;
#(
    parameter  int MEM_AW = 6,
    localparam int IDX_W  = (MEM_AW > RADR_W) ? MEM_AW : RADR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   my_id,
    input  logic              rd_req,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              ack_out,
    output logic              ack_oe,
    input  logic              ssr_we,
    input  logic [SSR_SW-1:0] ssr_sel,
    input  logic [LOC_W-1:0]  ssr_wdata,
    input  logic              ld_we,
    input  logic [1:0]        ld_space,
    input  logic [IDX_W-1:0]  ld_index,
    input  logic [DQ_W-1:0]   ld_data
);

    logic [SSR_SW-1:0] seg_sel;
    logic [LOC_W-1:0]  seg_val;
    logic              id_hit;
    logic [IDX_W+1:0]  mem_idx;
    logic [IDX_W+1:0]  idx_q;
    logic [DQ_W-1:0]   rdata;
    logic              accept;
    logic              mem_re;
    logic              drive_lead;
    logic              drive_data;

    rdr_ssr_bank u_ssr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ssr_we),
        .wsel  (ssr_sel),
        .wdata (ssr_wdata),
        .rsel  (seg_sel),
        .rdata (seg_val)
    );

    rdr_addr_decode #(.IDX_W(IDX_W)) u_dec (
        .word    (dq_in),
        .my_id   (my_id),
        .seg_val (seg_val),
        .seg_sel (seg_sel),
        .id_hit  (id_hit),
        .mem_idx (mem_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= mem_idx;
        end
    end

    rdr_store #(.IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_we),
        .waddr ({ld_space, ld_index}),
        .wdata (ld_data),
        .re    (mem_re),
        .raddr (idx_q),
        .rdata (rdata)
    );

    rdr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .id_hit     (id_hit),
        .accept     (accept),
        .mem_re     (mem_re),
        .drive_lead (drive_lead),
        .drive_data (drive_data),
        .ack_oe     (ack_oe),
        .ack_out    (ack_out)
    );

    always_comb begin
        dq_oe  = drive_lead | drive_data;
        dq_out = '0;
        if (drive_lead) begin
            dq_out = '1;
        end else if (drive_data) begin
            dq_out = rdata;
        end
    end

endmodule

// File: tb/rd_responder_bench.sv
`timescale 1ns/1ps
module rd_responder_bench;

    localparam int IDX_W = 6;
    localparam logic [4:0] OWN_ID = 5'd13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  my_id = OWN_ID;
    logic        rd_req = 1'b0;
    logic [67:0] dq_in = '0;
    logic [67:0] dq_out;
    logic        dq_oe;
    logic        ack_out;
    logic        ack_oe;
    logic        ssr_we = 1'b0;
    logic [2:0]  ssr_sel = '0;
    logic [14:0] ssr_wdata = '0;
    logic        ld_we = 1'b0;
    logic [1:0]  ld_space = '0;
    logic [IDX_W-1:0] ld_index = '0;
    logic [67:0] ld_data = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rd_responder u_rd_responder (
        .clk(clk), .rst_n(rst_n), .my_id(my_id), .rd_req(rd_req), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .ack_out(ack_out), .ack_oe(ack_oe),
        .ssr_we(ssr_we), .ssr_sel(ssr_sel), .ssr_wdata(ssr_wdata),
        .ld_we(ld_we), .ld_space(ld_space), .ld_index(ld_index), .ld_data(ld_data)
    );

    function automatic logic [67:0] pat(input logic [1:0] sp, input logic [5:0] idx);
        return {4'h5, sp, idx, 56'hC3A50F961E2D7B};
    endfunction

    function automatic logic [67:0] mk(input logic ind, input logic [2:0] seg,
                                      input logic [4:0] id, input logic [1:0] sp,
                                      input logic [14:0] low);
        logic [67:0] w;
        w = '0;
        w[29] = ind;
        w[28:26] = seg;
        w[25:21] = id;
        w[20:19] = sp;
        w[14:0] = low;
        return w;
    endfunction

    task automatic chk_bus(input string tag, input logic e_dqoe, input logic [67:0] e_dq,
                           input logic e_ackoe, input logic e_ack);
        logic [70:0] act, exp;
        act = {dq_oe, dq_out, ack_oe, ack_out};
        exp = {e_dqoe, e_dq, e_ackoe, e_ack};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; ends at the negedge of cycle 7
    task automatic read_check(input string tag, input logic [67:0] word,
                              input logic [67:0] exp, input logic poke);
        rd_req = 1'b1; dq_in = word;
        @(negedge clk); rd_req = 1'b0; dq_in = '0;
        chk_bus("R7 cycle2", 0, '0, 0, 0);
        @(negedge clk);
        if (poke) begin rd_req = 1'b1; dq_in = mk(0, 0, OWN_ID, 2'd0, 15'd9); end
        chk_bus("R7 cycle3", 0, '0, 0, 0);
        @(negedge clk); rd_req = 1'b0; dq_in = '0;
        chk_bus("R8 cycle4", 1, '1, 1, 0);
        @(negedge clk);
        chk_bus({"R9 ", tag}, 1, exp, 1, 1);
        @(negedge clk);
        chk_bus("R10 cycle6", 0, '0, 1, 0);
        @(negedge clk);
        chk_bus("R10 cycle7", 0, '0, 0, 0);
    endtask

    task automatic ssr_write(input logic [2:0] sel, input logic [14:0] val);
        ssr_we = 1'b1; ssr_sel = sel; ssr_wdata = val;
        @(negedge clk); ssr_we = 1'b0;
    endtask

    task automatic t_reset;
        chk_bus("R1 reset outputs", 0, '0, 0, 0);
    endtask

    task automatic t_load;
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 64; i++) begin
                ld_we = 1'b1; ld_space = 2'(s); ld_index = 6'(i); ld_data = pat(2'(s), 6'(i));
                @(negedge clk);
            end
        end
        ld_we = 1'b0;
    endtask

    task automatic t_spaces;
        read_check("R3 data space",  mk(0, 0, OWN_ID, 2'd0, 15'd5), pat(2'd0, 6'd5), 0);
        read_check("R3 mask space",  mk(0, 0, OWN_ID, 2'd1, 15'd5), pat(2'd1, 6'd5), 0);
        read_check("R3 sram space",  mk(0, 0, OWN_ID, 2'd2, 15'd5), pat(2'd2, 6'd5), 0);
        read_check("R3 reg space",   mk(0, 0, OWN_ID, 2'd3, 15'd5), pat(2'd3, 6'd5), 0);
        read_check("R4 direct alias", mk(0, 0, OWN_ID, 2'd0, 15'h7FC1), pat(2'd0, 6'd1), 0);
        read_check("R4 direct sram", mk(0, 0, OWN_ID, 2'd2, 15'd62), pat(2'd2, 6'd62), 0);
    endtask

    task automatic t_seg_reset;
        read_check("R12 reset seg zero", mk(1, 3'd7, OWN_ID, 2'd0, 15'h7FFE), pat(2'd0, 6'd2), 0);
    endtask

    task automatic t_indirect;
        ssr_write(3'd3, 15'h00A8);
        ssr_write(3'd5, 15'h01F2);
        read_check("R5 seg3 data", mk(1, 3'd3, OWN_ID, 2'd0, 15'h7F01), pat(2'd0, 6'h29), 0);
        read_check("R5 seg5 mask", mk(1, 3'd5, OWN_ID, 2'd1, 15'h0001), pat(2'd1, 6'h33), 0);
        read_check("R5 seg5 or no bits", mk(1, 3'd5, OWN_ID, 2'd2, 15'h0000), pat(2'd2, 6'h32), 0);
        ssr_write(3'd3, 15'h0003);
        read_check("R12 rewritten seg3", mk(1, 3'd3, OWN_ID, 2'd0, 15'h0000), pat(2'd0, 6'h03), 0);
    endtask

    task automatic t_register;
        read_check("R6 reg ignores indirect", mk(1, 3'd5, OWN_ID, 2'd3, 15'h7FEA), pat(2'd3, 6'h2A), 0);
    endtask

    task automatic t_id_miss;
        rd_req = 1'b1; dq_in = mk(0, 0, OWN_ID ^ 5'd1, 2'd0, 15'd5);
        @(negedge clk); rd_req = 1'b0; dq_in = '0;
        for (int c = 2; c <= 7; c++) begin
            chk_bus("R2 foreign id", 0, '0, 0, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_busy;
        read_check("R11 poked read", mk(0, 0, OWN_ID, 2'd1, 15'd40), pat(2'd1, 6'd40), 1);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk_bus("R11 no second read", 0, '0, 0, 0);
        end
        @(negedge clk);
    endtask

    task automatic t_back_to_back;
        read_check("R11 first", mk(0, 0, OWN_ID, 2'd2, 15'd17), pat(2'd2, 6'd17), 0);
        read_check("R11 second", mk(0, 0, OWN_ID, 2'd3, 15'd33), pat(2'd3, 6'd33), 0);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_load;
        t_seg_reset;
        t_spaces;
        t_indirect;
        t_register;
        t_id_miss;
        t_busy;
        t_back_to_back;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule